// File: doc/BRIEF.md
# Lockable Sync and ADC-Trigger Routing Registers

This block is a small memory-mapped control unit that decides which timing events leave the chip. A 5-bit code picks the source of one external synchronisation pin from a set of PWM and capture-unit sync pulses. Two enable masks build the external ADC start-of-conversion outputs. Output A is the OR of the enabled PWM trigger-A pulses, and output B is the same for trigger-B.

The unit holds three 32-bit registers at word offsets 0 (sync source), 2 (trigger enables) and 4 (locks), and a simple single-cycle bus reaches them. Every write needs a privileged-write enable. A write that lacks it is dropped without any error. Each routing register has a sticky lock bit. Once set, the lock bit blocks writes to that register but never reads. Only a system reset clears it. Boot code sets up the routing, then locks it, so later code cannot redirect the triggers.

Top module: `trig_route_regs`

## Requirements
- R1: After reset all three registers read 0, both trigger outputs are 0, and the sync output follows PWM source 0.
- R2: A write with `privWrEn` low changes no register, at any offset.
- R3: The sync-source code is stored in bits 28:24 of offset 0. Reads return it there, and bits 31:29 and 23:0 read 0.
- R4: Code 0 routes PWM source 0, code 2 routes PWM source 2, and code 24 routes capture source 0 to `extSyncOut`. A new code takes effect in the cycle after the write edge.
- R5: Every other sync code drives `extSyncOut` from PWM source 0, as code 0 does.
- R6: At offset 2, bits 31:28 and 15:12 read 0. All other bits are read/write storage with reset value 0.
- R7: `extTrigA` is the OR of `pwmTrigA[0]` gated by offset-2 bit 0 and `pwmTrigA[2]` gated by bit 2. The other stored bits do not affect it.
- R8: `extTrigB` is the OR of `pwmTrigB[0]` gated by offset-2 bit 16 and `pwmTrigB[2]` gated by bit 18.
- R9: At offset 4, writing 1 to bit 0 locks the sync register and writing 1 to bit 1 locks the trigger register. Writing 0 has no effect, and bits 31:2 read 0.
- R10: A locked register ignores writes but still reads back. Only reset clears a lock bit.
- R11: Offsets other than 0, 2 and 4 read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low system reset |
| busSel | input | 1 | Access valid this cycle |
| busWr | input | 1 | 1 for write, 0 for read |
| busAddr | input | 3 | Word offset |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational from address |
| privWrEn | input | 1 | Privileged-write enable |
| pwmSyncIn | input | 3 | PWM sync pulses |
| capSyncIn | input | 1 | Capture-unit sync pulses |
| pwmTrigA | input | 3 | PWM trigger-A pulses |
| pwmTrigB | input | 3 | PWM trigger-B pulses |
| extSyncOut | output | 1 | Routed sync pulse |
| extTrigA | output | 1 | Combined ADC trigger A |
| extTrigB | output | 1 | Combined ADC trigger B |

## Verification
A write lands on the rising edge where `busSel` and `busWr` are high. Read data and the routing outputs are combinational from the stored state, so a register's new value and its routing effect show up one edge after the write. The bench drives every access at the falling edge and lets the write edge pass. It then reads back and checks the outputs 1 ns after the next falling edge, with fresh random source pulses applied in that same half cycle. Reset checks follow the same rule and sample after the reset edge.

// File: rtl/trig_route_pkg.sv
`timescale 1ns/1ps
package trig_route_pkg;
  localparam int DATA_W      = 32;
  localparam int SEL_W       = 5;
  localparam int SEL_LSB     = 24;
  localparam int TRIG_B_LSB  = 16;
  localparam int LOCK_W      = 2;
  localparam int LOCK_SYNC   = 0;
  localparam int LOCK_TRIG   = 1;
  localparam int OFF_SYNC    = 0;
  localparam int OFF_TRIG    = 2;
  localparam int OFF_LOCK    = 4;
  localparam int CAP_CODE0   = 24;
  localparam logic [DATA_W-1:0] TRIG_RO_ZERO = (32'hF << 28) | (32'hF << 12);
  localparam logic [DATA_W-1:0] TRIG_WMASK   = ~TRIG_RO_ZERO;

  typedef enum logic [1:0] {RD_NONE, RD_SYNC, RD_TRIG, RD_LOCK} rdSel_t;

  typedef struct packed {
    logic   wrSync;
    logic   wrTrig;
    logic   wrLock;
    rdSel_t rdSel;
  } ctlStrobe_t;
endpackage

// File: rtl/trig_route_ctrl.sv
`timescale 1ns/1ps
module trig_route_ctrl
  import trig_route_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              privWrEn,
  input  logic [LOCK_W-1:0] lockQ,
  output ctlStrobe_t        strb
);
  logic hitSync, hitTrig, hitLock, wrOk;

  always_comb begin
    hitSync = busSel && (busAddr == ADDR_W'(OFF_SYNC));
    hitTrig = busSel && (busAddr == ADDR_W'(OFF_TRIG));
    hitLock = busSel && (busAddr == ADDR_W'(OFF_LOCK));
    wrOk    = busWr && privWrEn;

    strb.wrSync = hitSync && wrOk && !lockQ[LOCK_SYNC];
    strb.wrTrig = hitTrig && wrOk && !lockQ[LOCK_TRIG];
    strb.wrLock = hitLock && wrOk;

    if (hitSync)      strb.rdSel = RD_SYNC;
    else if (hitTrig) strb.rdSel = RD_TRIG;
    else if (hitLock) strb.rdSel = RD_LOCK;
    else              strb.rdSel = RD_NONE;
  end
endmodule

// File: rtl/trig_route_dp.sv
`timescale 1ns/1ps
module trig_route_dp
  import trig_route_pkg::*;
#(
  parameter int NUM_PWM = 3,
  parameter int NUM_CAP = 1,
  parameter logic [NUM_PWM-1:0] PWM_ROUTE = 3'b101,
  parameter logic [NUM_CAP-1:0] CAP_ROUTE = 1'b1
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobe_t         strb,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rdata,
  output logic [LOCK_W-1:0]  lockQ,
  input  logic [NUM_PWM-1:0] pwmSyncIn,
  input  logic [NUM_CAP-1:0] capSyncIn,
  input  logic [NUM_PWM-1:0] pwmTrigA,
  input  logic [NUM_PWM-1:0] pwmTrigB,
  output logic               extSyncOut,
  output logic               extTrigA,
  output logic               extTrigB
);
  logic [SEL_W-1:0]  syncSel;
  logic [DATA_W-1:0] trigQ;
  logic [NUM_PWM-1:0] termA, termB;
  logic selKnown;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncSel <= '0;
      trigQ   <= '0;
      lockQ   <= '0;
    end else begin
      if (strb.wrSync) syncSel <= wdata[SEL_LSB +: SEL_W];
      if (strb.wrTrig) trigQ   <= wdata & TRIG_WMASK;
      if (strb.wrLock) lockQ   <= lockQ | wdata[LOCK_W-1:0];
    end
  end

  always_comb begin
    unique case (strb.rdSel)
      RD_SYNC: rdata = DATA_W'(syncSel) << SEL_LSB;
      RD_TRIG: rdata = trigQ;
      RD_LOCK: rdata = DATA_W'(lockQ);
      default: rdata = '0;
    endcase
  end

  always_comb begin
    extSyncOut = pwmSyncIn[0];
    selKnown   = 1'b0;
    for (int i = 0; i < NUM_PWM; i++) begin
      if (PWM_ROUTE[i] && syncSel == SEL_W'(i)) begin
        extSyncOut = pwmSyncIn[i];
        selKnown   = 1'b1;
      end
    end
    for (int j = 0; j < NUM_CAP; j++) begin
      if (CAP_ROUTE[j] && syncSel == SEL_W'(CAP_CODE0 + j)) begin
        extSyncOut = capSyncIn[j];
        selKnown   = 1'b1;
      end
    end
  end

  for (genvar g = 0; g < NUM_PWM; g++) begin : gTrig
    if (PWM_ROUTE[g]) begin : gOn
      assign termA[g] = pwmTrigA[g] & trigQ[g];
      assign termB[g] = pwmTrigB[g] & trigQ[TRIG_B_LSB + g];
    end else begin : gOff
      assign termA[g] = 1'b0;
      assign termB[g] = 1'b0;
    end
  end

  assign extTrigA = |termA;
  assign extTrigB = |termB;

  // R10: lock bits never fall while out of reset
  assert_lock_sticky_R10: assert property (@(posedge clk) disable iff (!rstN)
    lockQ[LOCK_SYNC] |=> lockQ[LOCK_SYNC]);
  assert_lock1_sticky_R10: assert property (@(posedge clk) disable iff (!rstN)
    lockQ[LOCK_TRIG] |=> lockQ[LOCK_TRIG]);
  // R10: a locked register keeps its value
  assert_sync_locked_R10: assert property (@(posedge clk) disable iff (!rstN)
    lockQ[LOCK_SYNC] |=> $stable(syncSel));
  assert_trig_locked_R10: assert property (@(posedge clk) disable iff (!rstN)
    lockQ[LOCK_TRIG] |=> $stable(trigQ));
  // R6: read-as-zero trigger bits never hold a 1
  assert_trig_rsvd_R6: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrTrig |=> (trigQ & TRIG_RO_ZERO) == '0);
  // R5: unsupported codes route PWM source 0
  assert_fallback_R5: assert property (@(posedge clk) disable iff (!rstN)
    !selKnown |-> extSyncOut == pwmSyncIn[0]);
endmodule

// File: rtl/trig_route_regs.sv
`timescale 1ns/1ps
module trig_route_regs
  import trig_route_pkg::*;
#(
  parameter int ADDR_W  = 3,
  parameter int NUM_PWM = 3,
  parameter int NUM_CAP = 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busSel,
  input  logic               busWr,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [31:0]        busWdata,
  output logic [31:0]        busRdata,
  input  logic               privWrEn,
  input  logic [NUM_PWM-1:0] pwmSyncIn,
  input  logic [NUM_CAP-1:0] capSyncIn,
  input  logic [NUM_PWM-1:0] pwmTrigA,
  input  logic [NUM_PWM-1:0] pwmTrigB,
  output logic               extSyncOut,
  output logic               extTrigA,
  output logic               extTrigB
);
  ctlStrobe_t        strb;
  logic [LOCK_W-1:0] lockQ;

  trig_route_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .privWrEn(privWrEn), .lockQ(lockQ), .strb(strb)
  );

  trig_route_dp #(.NUM_PWM(NUM_PWM), .NUM_CAP(NUM_CAP)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .wdata(busWdata),
    .rdata(busRdata), .lockQ(lockQ),
    .pwmSyncIn(pwmSyncIn), .capSyncIn(capSyncIn),
    .pwmTrigA(pwmTrigA), .pwmTrigB(pwmTrigB),
    .extSyncOut(extSyncOut), .extTrigA(extTrigA), .extTrigB(extTrigB)
  );

  // R2: unprivileged write leaves the lock state unchanged
  assert_nopriv_lock_R2: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWr && !privWrEn) |=> $stable(lockQ));
  // R9: lock register upper bits read zero
  assert_lock_rsvd_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busAddr == ADDR_W'(OFF_LOCK)) |-> busRdata[31:LOCK_W] == '0);
  // R11: unmapped offsets read zero
  assert_unmapped_R11: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busAddr != ADDR_W'(OFF_SYNC) && busAddr != ADDR_W'(OFF_TRIG)
     && busAddr != ADDR_W'(OFF_LOCK)) |-> busRdata == '0);
endmodule

// File: tb/sim_trig_route_regs.sv
`timescale 1ns/1ps
module sim_trig_route_regs;
  logic clk = 0, rstN = 0;
  logic busSel = 0, busWr = 0, privWrEn = 0;
  logic [2:0] busAddr = 0;
  logic [31:0] busWdata = 0;
  wire  [31:0] busRdata;
  logic [2:0] pwmSyncIn = 0, pwmTrigA = 0, pwmTrigB = 0;
  logic [0:0] capSyncIn = 0;
  wire extSyncOut, extTrigA, extTrigB;

  int total = 0, failed = 0;
  logic [4:0]  mSync;
  logic [31:0] mTrig;
  logic [1:0]  mLock;

  always #4 clk = ~clk;

  trig_route_regs u0 (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .privWrEn(privWrEn),
    .pwmSyncIn(pwmSyncIn), .capSyncIn(capSyncIn), .pwmTrigA(pwmTrigA),
    .pwmTrigB(pwmTrigB), .extSyncOut(extSyncOut), .extTrigA(extTrigA),
    .extTrigB(extTrigB)
  );

  function automatic logic [31:0] expRead(input logic [2:0] a);
    case (a)
      3'd0: return {3'b0, mSync, 24'b0};
      3'd2: return mTrig;
      3'd4: return {30'b0, mLock};
      default: return 32'b0;
    endcase
  endfunction

  function automatic logic expSync();
    case (mSync)
      5'd2:  return pwmSyncIn[2];
      5'd24: return capSyncIn[0];
      default: return pwmSyncIn[0];
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic modelWrite(input logic [2:0] a, input logic [31:0] d, input logic p);
    if (p) case (a)
      3'd0: if (!mLock[0]) mSync = d[28:24];
      3'd2: if (!mLock[1]) mTrig = d & 32'h0FFF_0FFF;
      3'd4: mLock = mLock | d[1:0];
      default: ;
    endcase
  endtask

  task automatic busWrite(input logic [2:0] a, input logic [31:0] d, input logic p);
    @(negedge clk);
    busSel = 1; busWr = 1; busAddr = a; busWdata = d; privWrEn = p;
    @(posedge clk);
    modelWrite(a, d, p);
    @(negedge clk);
    busSel = 0; busWr = 0; privWrEn = 0;
  endtask

  task automatic checkRead(input logic [2:0] a, input string tag);
    logic [31:0] e;
    busSel = 1; busWr = 0; busAddr = a;
    #1;
    e = expRead(a);
    check(busRdata === e, tag, busRdata, e);
    busSel = 0;
  endtask

  task automatic checkRoute(input string tag);
    logic ea, eb, es;
    pwmSyncIn = 3'($urandom); capSyncIn = 1'($urandom);
    pwmTrigA = 3'($urandom); pwmTrigB = 3'($urandom);
    #1;
    es = expSync();
    ea = |(mTrig[2:0] & 3'b101 & pwmTrigA);
    eb = |(mTrig[18:16] & 3'b101 & pwmTrigB);
    check(extSyncOut === es, {tag, " sync"}, 32'(extSyncOut), 32'(es));
    check(extTrigA === ea, {tag, " trigA"}, 32'(extTrigA), 32'(ea));
    check(extTrigB === eb, {tag, " trigB"}, 32'(extTrigB), 32'(eb));
  endtask

  task automatic checkAll(input string tag);
    checkRead(3'd0, {tag, " R3 sync read"});
    checkRead(3'd2, {tag, " R6 trig read"});
    checkRead(3'd4, {tag, " R9 lock read"});
    checkRoute({tag, " R4 R7 R8 route"});
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 0;
    @(posedge clk); mSync = 0; mTrig = 0; mLock = 0;
    @(negedge clk); rstN = 1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failed++; total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    mSync = 0; mTrig = 0; mLock = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1;
    @(negedge clk);
    checkAll("R1 reset");
    for (int k = 0; k < 8; k++) begin
      checkRead(3'(k), "R1 R11 reset read");
      @(negedge clk);
    end

    // Directed: supported codes, fallback, unprivileged
    busWrite(3'd0, 32'h0200_0000, 1); checkAll("R4 code2");
    busWrite(3'd0, 32'h1800_0000, 1); checkAll("R4 code24");
    busWrite(3'd0, 32'hFFFF_FFFF, 1); checkAll("R5 code31");
    busWrite(3'd0, 32'h0100_0000, 1); checkAll("R5 code1");
    busWrite(3'd0, 32'h1800_0000, 0); checkAll("R2 nopriv sync");
    busWrite(3'd2, 32'hFFFF_FFFF, 1); checkAll("R6 trig all ones");
    busWrite(3'd2, 32'h0FFA_0FFA, 1); checkAll("R7 reserved only");
    busWrite(3'd2, 32'h0000_0000, 0); checkAll("R2 nopriv trig");
    busWrite(3'd6, 32'hFFFF_FFFF, 1); checkAll("R11 unmapped write");
    checkRead(3'd6, "R11 unmapped read");

    // Random mix without locks
    for (int n = 0; n < 400; n++) begin
      logic [2:0] a;
      logic [31:0] d;
      int pick;
      pick = $urandom_range(0, 9);
      a = (pick < 4) ? 3'd0 : (pick < 8) ? 3'd2 : 3'($urandom_range(5, 7) | 1);
      d = $urandom;
      if (a == 3'd0 && $urandom_range(0, 1) == 1)
        d[28:24] = ($urandom_range(0, 1) == 1) ? 5'd2 : 5'd24;
      busWrite(a, d, $urandom_range(0, 3) != 0);
      checkAll("R2 R3 R4 R6 R7 R8 random");
    end

    // Locks
    busWrite(3'd0, 32'h0200_0000, 1);
    busWrite(3'd2, 32'h0005_0005, 1);
    busWrite(3'd4, 32'h0000_0000, 1); checkAll("R9 zero write");
    busWrite(3'd4, 32'hFFFF_FFFD, 0); checkAll("R2 nopriv lock");
    busWrite(3'd4, 32'hFFFF_FFFD, 1); checkAll("R9 lock sync");
    busWrite(3'd0, 32'h1800_0000, 1); checkAll("R10 sync locked");
    busWrite(3'd2, 32'h0000_0000, 1); checkAll("R10 trig still open");
    busWrite(3'd4, 32'h0000_0002, 1); checkAll("R9 lock trig");
    busWrite(3'd2, 32'h0005_0005, 1); checkAll("R10 trig locked");
    busWrite(3'd4, 32'h0000_0000, 1); checkAll("R10 lock stays");
    for (int n = 0; n < 20; n++) begin
      busWrite(3'($urandom_range(0, 7)), $urandom, 1);
      checkAll("R10 locked random");
    end
    doReset();
    checkAll("R1 R10 reset clears");
    busWrite(3'd0, 32'h1800_0000, 1); checkAll("R10 unlocked after reset");

    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule